// File: doc/BRIEF.md
# Branch Trace Message Capture Unit

This block sits on the system side of a processor bus and listens for the pair of special bus cycles that the processor emits after every taken branch while branch tracing is on. Each such cycle is answered with a one-clock ready acknowledge. The first cycle of a pair carries the branch source (selector and instruction pointer), the second carries the branch target together with the target's operating mode and default operand size.

The unit holds the source half until the matching target half arrives and then writes one combined record into a small FIFO. A downstream consumer drains that FIFO through a valid/ready stream. Protocol problems are reported on dedicated flag outputs: invalid target mode, nonzero reserved address bits, a target with no source, a source that replaces an unpaired source, and a record lost to a full FIFO.

Top module: `btm_capture`

## Requirements
- R1: A bus cycle is a trace cycle only when `bus_valid`, `bus_special` and `bus_be == 8'hDF` hold together in the same clock; any other cycle gets no acknowledge, raises no flag and leaves the pending source untouched.
- R2: `bus_ack` is high for exactly one clock, the clock that follows the one in which the trace cycle was on the bus.
- R3: `bus_addr[31]` selects the phase (0 = source, 1 = target); a source cycle captures its selector from `bus_addr[19:4]` and its instruction pointer from `bus_data[31:0]`.
- R4: A target cycle with a pending source writes one record to the FIFO, packed MSB first as {source selector[15:0], source pointer[31:0], target selector[15:0], target pointer[31:0], target mode = `bus_addr[30:29]`, operand size = `bus_addr[28]`} (99 bits); records leave on `rec_data` in arrival order, one per clock in which `rec_valid` and `rec_ready` are both high.
- R5: A target cycle with mode 2'b01 pulses `err_mode` for one clock, aligned with `bus_ack`; the record is still stored.
- R6: A trace cycle with any of `bus_addr[27:20]` nonzero or `bus_addr[3]` set pulses `err_format` for one clock, aligned with `bus_ack`; the cycle is otherwise handled normally.
- R7: A target cycle with no pending source pulses `err_orphan`, aligned with `bus_ack`, and produces no record.
- R8: A source cycle that arrives while a source is already pending pulses `err_seq`, aligned with `bus_ack`, and its fields replace the pending ones.
- R9: The FIFO holds 4 records; a completed record arriving while 4 are held is dropped and sets `err_overflow`, which stays high until reset.
- R10: Synchronous active-high reset clears the pending source and FIFO and drives `bus_ack`, `rec_valid` and all error flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus cycle strobe, one clock per cycle |
| bus_special | input | 1 | Special-cycle qualifier |
| bus_be | input | 8 | Byte enables |
| bus_addr | input | 32 | Address bus |
| bus_data | input | 32 | Data bus |
| bus_ack | output | 1 | Ready acknowledge for a trace cycle |
| rec_valid | output | 1 | FIFO head holds a record |
| rec_ready | input | 1 | Consumer accepts the head record |
| rec_data | output | 99 | Head record |
| err_mode | output | 1 | Invalid target mode pulse |
| err_format | output | 1 | Reserved address bits nonzero pulse |
| err_orphan | output | 1 | Target without source pulse |
| err_seq | output | 1 | Source replaced pulse |
| err_overflow | output | 1 | Sticky record-dropped flag |

## Verification
The bench drives near-miss cycles (right byte enables without the qualifier, the qualifier with other byte enables); a decoder that checked only one of them would acknowledge or flag those. It sends two sources back to back before a target, where a design that kept the first source would emit a record with the stale pointer, and a target with no source, where a design that paired it with leftover state would emit a spurious record. It fills the FIFO with the consumer stalled and sends a fifth record, so a design that overwrote the head, or let the overflow flag clear, would show a wrong record order or a dropped flag after draining. Records are compared field by field against the bench's own pairing model, so a swapped field or shifted selector shows up as a mismatch.

// File: rtl/btm_pkg.sv
package btm_pkg;
  localparam int SEL_W = 16;
  localparam int IP_W  = 32;
  localparam int REC_W = 2 * SEL_W + 2 * IP_W + 3;
  localparam logic [7:0] TRACE_BE = 8'hDF;

  // Record, MSB first
  typedef struct packed {
    logic [SEL_W-1:0] src_sel;
    logic [IP_W-1:0]  src_ip;
    logic [SEL_W-1:0] tgt_sel;
    logic [IP_W-1:0]  tgt_ip;
    logic [1:0]       mode;
    logic             size;
  } btm_rec_t;

  // Decoded view of the current bus cycle
  typedef struct packed {
    logic             hit;
    logic             is_tgt;
    logic             fmt_bad;
    logic             mode_bad;
    logic [SEL_W-1:0] sel;
    logic [1:0]       mode;
    logic             size;
  } btm_dec_t;
endpackage

// File: rtl/btm_decode.sv
module btm_decode
  import btm_pkg::*;
(
  input  logic        bus_valid,
  input  logic        bus_special,
  input  logic [7:0]  bus_be,
  input  logic [31:0] bus_addr,
  output btm_dec_t    dec
);
  always_comb begin
    dec.hit      = bus_valid && bus_special && (bus_be == TRACE_BE);
    dec.is_tgt   = bus_addr[31];
    dec.fmt_bad  = dec.hit && ((|bus_addr[27:20]) || bus_addr[3]);
    dec.mode_bad = dec.hit && bus_addr[31] && (bus_addr[30:29] == 2'b01);
    dec.sel      = bus_addr[19:4];
    dec.mode     = bus_addr[30:29];
    dec.size     = bus_addr[28];
  end
endmodule

// File: rtl/btm_pair.sv
module btm_pair
  import btm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  btm_dec_t        dec,
  input  logic [IP_W-1:0] ip,
  output logic            ack,
  output logic            wr_en,
  output btm_rec_t        wr_rec,
  output logic            err_mode,
  output logic            err_format,
  output logic            err_orphan,
  output logic            err_seq
);
  logic             pend_v;
  logic [SEL_W-1:0] pend_sel;
  logic [IP_W-1:0]  pend_ip;

  always_comb begin
    wr_en          = dec.hit && dec.is_tgt && pend_v;
    wr_rec.src_sel = pend_sel;
    wr_rec.src_ip  = pend_ip;
    wr_rec.tgt_sel = dec.sel;
    wr_rec.tgt_ip  = ip;
    wr_rec.mode    = dec.mode;
    wr_rec.size    = dec.size;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_sel   <= '0;
      pend_ip    <= '0;
      ack        <= 1'b0;
      err_mode   <= 1'b0;
      err_format <= 1'b0;
      err_orphan <= 1'b0;
      err_seq    <= 1'b0;
    end else begin
      ack        <= dec.hit;
      err_mode   <= dec.mode_bad;
      err_format <= dec.fmt_bad;
      err_orphan <= dec.hit && dec.is_tgt && !pend_v;
      err_seq    <= dec.hit && !dec.is_tgt && pend_v;
      if (dec.hit) begin
        if (dec.is_tgt) begin
          pend_v <= 1'b0;
        end else begin
          pend_v   <= 1'b1;
          pend_sel <= dec.sel;
          pend_ip  <= ip;
        end
      end
    end
  end
endmodule

// File: rtl/btm_fifo.sv
module btm_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nx;
  logic          full, push, pop;

  always_comb begin
    full     = (count == FULL_CNT);
    push     = wr_en && !full;
    pop      = rd_valid && rd_ready;
    count_nx = count;
    if (push && !pop) count_nx = count + 1'b1;
    else if (!push && pop) count_nx = count - 1'b1;
  end

  // Storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      count    <= count_nx;
      rd_valid <= (count_nx != '0);
      if (wr_en && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/btm_capture.sv
module btm_capture
  import btm_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_special,
  input  logic [7:0]       bus_be,
  input  logic [31:0]      bus_addr,
  input  logic [IP_W-1:0]  bus_data,
  output logic             bus_ack,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic [REC_W-1:0] rec_data,
  output logic             err_mode,
  output logic             err_format,
  output logic             err_orphan,
  output logic             err_seq,
  output logic             err_overflow
);
  btm_dec_t dec;
  btm_rec_t wr_rec;
  logic     wr_en;

  btm_decode u_dec (
    .bus_valid   (bus_valid),
    .bus_special (bus_special),
    .bus_be      (bus_be),
    .bus_addr    (bus_addr),
    .dec         (dec)
  );

  btm_pair u_pair (
    .clk        (clk),
    .rst        (rst),
    .dec        (dec),
    .ip         (bus_data),
    .ack        (bus_ack),
    .wr_en      (wr_en),
    .wr_rec     (wr_rec),
    .err_mode   (err_mode),
    .err_format (err_format),
    .err_orphan (err_orphan),
    .err_seq    (err_seq)
  );

  btm_fifo #(.DEPTH(DEPTH), .W(REC_W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_rec),
    .rd_valid (rec_valid),
    .rd_ready (rec_ready),
    .rd_data  (rec_data),
    .ovf      (err_overflow)
  );
endmodule

// File: rtl/btm_capture_chk.sv
module btm_capture_chk
  import btm_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_special,
  input logic [7:0]       bus_be,
  input logic [31:0]      bus_addr,
  input logic [IP_W-1:0]  bus_data,
  input logic             bus_ack,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [REC_W-1:0] rec_data,
  input logic             err_mode,
  input logic             err_format,
  input logic             err_orphan,
  input logic             err_seq,
  input logic             err_overflow
);
  logic trace;
  assign trace = bus_valid && bus_special && (bus_be == 8'hDF);

  assert_ack_after_trace_R2: assert property (@(posedge clk) disable iff (rst)
    trace |=> bus_ack);
  assert_no_ack_otherwise_R1: assert property (@(posedge clk) disable iff (rst)
    !trace |=> !bus_ack);
  assert_bad_mode_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (trace && bus_addr[31] && bus_addr[30:29] == 2'b01) |=> err_mode);
  assert_format_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (trace && ((|bus_addr[27:20]) || bus_addr[3])) |=> err_format);
  assert_flags_need_trace_R1: assert property (@(posedge clk) disable iff (rst)
    !trace |=> !(err_mode || err_format || err_orphan || err_seq));
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err_overflow |=> err_overflow);
  assert_head_held_R4: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));
endmodule

bind btm_capture btm_capture_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/btm_capture_test.sv
`timescale 1ns/1ps
module btm_capture_test;
  localparam int DEPTH = 4;
  localparam int RW    = 99;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0, bus_special = 1'b0;
  logic [7:0]    bus_be = 8'hFF;
  logic [31:0]   bus_addr = '0, bus_data = '0;
  logic          bus_ack, rec_valid, rec_ready = 1'b0;
  logic [RW-1:0] rec_data;
  logic          err_mode, err_format, err_orphan, err_seq, err_overflow;

  always #2 clk = ~clk;

  btm_capture #(.DEPTH(DEPTH)) uut (.*);

  int checks = 0, errors = 0;
  logic [RW-1:0] sb [$];
  logic        pend_m = 1'b0;
  logic [15:0] pend_sel_m = '0;
  logic [31:0] pend_ip_m = '0;
  logic        ovf_m = 1'b0;
  logic s_ack, s_mode, s_fmt, s_orph, s_seq, s_ovf;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One bus cycle; samples the outputs one clock later
  task automatic cyc(input logic sp, input logic [7:0] be, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_special = sp; bus_be = be; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_special = 1'b0; bus_be = 8'hFF; bus_addr = '0;
    s_ack = bus_ack; s_mode = err_mode; s_fmt = err_format;
    s_orph = err_orphan; s_seq = err_seq; s_ovf = err_overflow;
  endtask

  task automatic src(input logic [15:0] sel, input logic [31:0] ip, input logic [31:0] junk);
    cyc(1'b1, 8'hDF, {1'b0, 3'b101, 8'h00, sel, 4'h0} | junk, ip);
    chk("R2 ack after source", 1'(s_ack), 1'b1);
    chk("R6 format flag on source", 1'(s_fmt), 1'(junk != 0));
    chk("R8 sequence flag", 1'(s_seq), 1'(pend_m));
    chk("R7 no orphan on source", 1'(s_orph), 1'b0);
    pend_m = 1'b1; pend_sel_m = sel; pend_ip_m = ip;
  endtask

  task automatic tgt(input logic [15:0] sel, input logic [31:0] ip, input logic [1:0] mode,
                     input logic sz, input logic [31:0] junk);
    logic had = pend_m;
    cyc(1'b1, 8'hDF, {1'b1, mode, sz, 8'h00, sel, 4'h0} | junk, ip);
    chk("R2 ack after target", 1'(s_ack), 1'b1);
    chk("R5 mode flag", 1'(s_mode), 1'(mode == 2'b01));
    chk("R6 format flag on target", 1'(s_fmt), 1'(junk != 0));
    chk("R7 orphan flag", 1'(s_orph), 1'(!had));
    chk("R8 no sequence flag on target", 1'(s_seq), 1'b0);
    if (had) begin
      if (sb.size() >= DEPTH) ovf_m = 1'b1;
      else sb.push_back({pend_sel_m, pend_ip_m, sel, ip, mode, sz});
    end
    chk("R9 overflow flag", 1'(s_ovf), 1'(ovf_m));
    pend_m = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares every transferred record with the scoreboard
  always begin
    @(negedge clk); #1;
    if (!rst && rec_valid && rec_ready) begin
      if (sb.size() == 0) begin
        chk("R4 unexpected record", 128'(rec_data), 128'h0);
        if (rec_data == '0) begin errors++; $display("FAIL R4: actual record with empty scoreboard, expected none"); end
      end else begin
        chk("R4 record contents and order", 128'(rec_data), 128'(sb.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset ack", 1'(bus_ack), 1'b0);
    chk("R10 reset rec_valid", 1'(rec_valid), 1'b0);
    chk("R10 reset flags", 128'({err_mode, err_format, err_orphan, err_seq, err_overflow}), 128'h0);
    rec_ready = 1'b1;

    // R1 near misses: target-phase address, but not a trace cycle
    cyc(1'b1, 8'hFF, 32'h8000_0010, 32'h1);
    chk("R1 wrong byte enables no ack", 1'(s_ack), 1'b0);
    chk("R1 wrong byte enables no orphan", 1'(s_orph), 1'b0);
    cyc(1'b0, 8'hDF, 32'h8000_0010, 32'h1);
    chk("R1 no qualifier no ack", 1'(s_ack), 1'b0);
    chk("R1 no qualifier no flag", 128'({s_mode, s_fmt, s_orph, s_seq}), 128'h0);

    // R3 R4 normal pairs, several modes and sizes
    src(16'h1234, 32'hDEAD_BEEF, 32'h0);
    tgt(16'h00F0, 32'h0040_1000, 2'b10, 1'b1, 32'h0);
    idle(1);
    chk("R2 ack lasts one clock", 1'(bus_ack), 1'b0);
    src(16'hFFFF, 32'h0000_0001, 32'h0);
    tgt(16'h8001, 32'hFFFF_FFFE, 2'b00, 1'b0, 32'h0);
    src(16'h0008, 32'h1357_9BDF, 32'h0);
    tgt(16'h7777, 32'h2468_ACE0, 2'b11, 1'b0, 32'h0);

    // R1: a non-trace cycle between halves leaves the pending source alone
    src(16'hA5A5, 32'h1111_2222, 32'h0);
    cyc(1'b1, 8'hFE, 32'h0000_1230, 32'h9999_9999);
    chk("R1 ignored source-like cycle no seq", 1'(s_seq), 1'b0);
    tgt(16'h5A5A, 32'h3333_4444, 2'b10, 1'b1, 32'h0);

    // R5 invalid mode still stores a record
    src(16'h0102, 32'h0A0B_0C0D, 32'h0);
    tgt(16'h0304, 32'h0E0F_1011, 2'b01, 1'b1, 32'h0);

    // R6 reserved bits: bit 3, then bits 27:20
    src(16'h0011, 32'h5555_0000, 32'h0000_0008);
    tgt(16'h0022, 32'h6666_0000, 2'b10, 1'b0, 32'h0810_0000);

    // R7 orphan target
    tgt(16'hBEEF, 32'hCAFE_F00D, 2'b10, 1'b1, 32'h0);
    idle(3);
    chk("R7 orphan produced no record", 1'(rec_valid), 1'b0);

    // R8 source replaced by a second source
    src(16'h0AAA, 32'hAAAA_AAAA, 32'h0);
    src(16'h0BBB, 32'hBBBB_BBBB, 32'h0);
    tgt(16'h0CCC, 32'hCCCC_CCCC, 2'b00, 1'b1, 32'h0);
    idle(3);
    chk("R4 scoreboard drained", 128'(sb.size()), 128'h0);

    // R9 fill with consumer stalled, fifth record dropped
    rec_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin
      src(16'(16'h0100 + i), 32'(32'h1000_0000 + i), 32'h0);
      tgt(16'(16'h0200 + i), 32'(32'h2000_0000 + i), 2'b10, 1'(i % 2), 32'h0);
    end
    chk("R9 head valid while full", 1'(rec_valid), 1'b1);
    chk("R9 overflow set", 1'(err_overflow), 1'b1);
    rec_ready = 1'b1;
    idle(8);
    chk("R9 four records drained", 128'(sb.size()), 128'h0);
    chk("R9 FIFO empty after drain", 1'(rec_valid), 1'b0);
    chk("R9 overflow sticky", 1'(err_overflow), 1'b1);

    // R10 reset mid-pair clears pending and sticky flag
    src(16'h4444, 32'h4444_4444, 32'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    pend_m = 1'b0; ovf_m = 1'b0;
    @(negedge clk);
    chk("R10 overflow cleared", 1'(err_overflow), 1'b0);
    tgt(16'h4545, 32'h4545_4545, 2'b00, 1'b0, 32'h0);
    idle(3);
    chk("R10 no record after reset", 1'(rec_valid), 1'b0);

    report();
    $finish;
  end
endmodule